// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide programming front end of an eight-line interrupt controller. It sits on a two-address register port. Address 0 carries commands. Address 1 carries either the interrupt mask or the next word of an initialization sequence, depending on where a small sequencer currently stands. The block decodes every write and holds the resulting configuration fields. It also emits one-cycle strobes that tell a separate controller core (priority resolution, request and in-service bookkeeping) what to do.

An initialization command resets the programmable state and starts a sequence of up to three further data words: a vector base, a cascade word that is consumed without effect, and an optional mode word. The mode word is expected only when bit 0 of the initialization command asked for it. Outside that sequence, data writes load the mask. A select command chooses which core register a command-address read returns. It can also arm a one-shot poll, which replaces the next read with the highest pending request reported by the core.

Reads are combinational from the current state. All state changes take effect on the clock edge that ends the access cycle.

Top module: `pic_prog_seq`

## Requirements
- R1: After reset, the mask is 0x00, the sequencer phase is 0 (idle), all mode flags are 0, poll is disarmed and no strobe is high.
- R2: A write at address 0 with data bit 4 set is an initialization command. On the following cycle, init_stb_o is high for one cycle, the phase is 1, fourth_word_o equals data bit 0, and the mask, special-mask flag and ISR-read select are all 0.
- R3: An initialization command clears the nested-mode and auto-EOI flags only when its bit 0 is 0. When bit 0 is 1, both flags keep their values.
- R4: Phase encoding is 0 idle, 1 base word, 2 cascade word, 3 mode word. In phase 1, a data write stores data AND 0xF8 as the vector base and moves to phase 2. In phase 2, a data write moves to phase 3 if a fourth word was requested and to phase 0 otherwise.
- R5: In phase 3, a data write sets the nested-mode flag from data bit 4 and the auto-EOI flag from data bit 1, then returns to phase 0.
- R6: A data write in phase 0 loads the mask with the full data byte. A data write in any other phase leaves the mask unchanged.
- R7: A write at address 0 with bit 4 clear and bit 3 set is a select command. If bit 1 is set, bit 0 sets the read select (1 = ISR, 0 = IRR). If bit 6 is set, bit 5 sets the special-mask flag. Otherwise each of these fields keeps its value.
- R8: A select command with bit 2 set arms poll. The next read of either address returns 0x80 OR the core's pending line number if the core reports a pending request, or 0x07 if it does not. That read disarms poll. On the cycle after it, poll_ack_o is high with the line number if a request was pending.
- R9: With poll disarmed, an address-0 read returns the core's ISR or IRR as selected, and an address-1 read returns the mask.
- R10: A write at address 0 with bits 4 and 3 clear is an operation command with its code in bits 7:5. Code 4 sets the rotate-on-auto-EOI flag and code 0 clears it. Neither code raises cmd_stb_o.
- R11: Operation codes 1, 3, 5, 6 and 7 raise cmd_stb_o for exactly one cycle, with cmd_op_o equal to the code and cmd_irq_o equal to data bits 2:0. Code 2 raises no strobe.
- R12: Bits 3 and 1 of the initialization command have no effect: an initialization command with them set behaves exactly as one with them clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| addr | input | 1 | Register address (0 command, 1 data) |
| wdata | input | 8 | Write data |
| irr_i | input | 8 | Request register from the core |
| isr_i | input | 8 | In-service register from the core |
| poll_valid_i | input | 1 | Core has a request above current priority |
| poll_irq_i | input | 3 | Line number of that request |
| rd_data | output | 8 | Read data |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| init_phase_o | output | 2 | Sequencer phase |
| fourth_word_o | output | 1 | Mode word expected |
| nest_mode_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Automatic end of interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end of interrupt |
| spec_mask_o | output | 1 | Special mask mode |
| read_isr_o | output | 1 | Address-0 read returns ISR |
| poll_armed_o | output | 1 | Next read is a poll |
| init_stb_o | output | 1 | One-cycle pulse: core must reinitialize |
| cmd_stb_o | output | 1 | One-cycle pulse: operation command |
| cmd_op_o | output | 3 | Operation code of the pulse |
| cmd_irq_o | output | 3 | Line field of the pulse |
| poll_ack_o | output | 1 | One-cycle pulse: poll consumed a request |
| poll_irq_ack_o | output | 3 | Line consumed by the poll |

## Verification
The sequencer is driven through three initialization sequences: one with a mode word, one with the level and single bits set as well as bit 0, and one without bit 0. Together they separate "mode flags cleared", "mode flags kept" and "phase 2 skips phase 3". Data writes in every phase show whether the mask follows the phase. Select commands with and without their enable bits show whether the gating bits guard the fields. Every operation code is written once, which distinguishes strobing codes from the level-setting and no-op codes. Poll reads with and without a pending request, followed by an ordinary read, separate the poll encoding from the spurious code and show that poll is one-shot.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BASE = 2'd1,
      PH_CASC = 2'd2,
      PH_MODE = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_INIT = 3'd1,
      K_SEL  = 3'd2,
      K_OPR  = 3'd3,
      K_DATA = 3'd4
   } kind_e;

   typedef enum logic [2:0] {
      OP_ROT_OFF       = 3'd0,
      OP_EOI           = 3'd1,
      OP_NOP           = 3'd2,
      OP_EOI_SPEC      = 3'd3,
      OP_ROT_ON        = 3'd4,
      OP_EOI_ROT       = 3'd5,
      OP_SET_PRIO      = 3'd6,
      OP_EOI_ROT_SPEC  = 3'd7
   } op_e;
endpackage

// File: rtl/pic_seq_decode.sv
module pic_seq_decode
   import pic_seq_pkg::*;
(
   input  logic       wr_en,
   input  logic       addr,
   input  logic [4:0] cmd_hi,
   output kind_e      kind,
   output op_e        op
);
   // cmd_hi holds write data bits 7:3
   always_comb begin
      kind = K_NONE;
      if (wr_en) begin
         if (addr)           kind = K_DATA;
         else if (cmd_hi[1]) kind = K_INIT;
         else if (cmd_hi[0]) kind = K_SEL;
         else                kind = K_OPR;
      end
   end

   assign op = op_e'(cmd_hi[4:2]);
endmodule

// File: rtl/pic_seq_init.sv
module pic_seq_init
   import pic_seq_pkg::*;
#(
   parameter int LINES = 8,
   localparam int DATA_W = LINES,
   localparam int IRQ_W = $clog2(LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  kind_e             kind,
   input  logic [DATA_W-1:0] wdata,
   output phase_e            phase,
   output logic              need4,
   output logic [DATA_W-1:0] vec_base,
   output logic              nest_mode,
   output logic              auto_eoi,
   output logic              init_stb
);
   localparam logic [DATA_W-1:0] BASE_MASK = {{(DATA_W-IRQ_W){1'b1}}, {IRQ_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         need4     <= 1'b0;
         vec_base  <= '0;
         nest_mode <= 1'b0;
         auto_eoi  <= 1'b0;
         init_stb  <= 1'b0;
      end else begin
         init_stb <= 1'b0;
         if (kind == K_INIT) begin
            need4    <= wdata[0];
            phase    <= PH_BASE;
            init_stb <= 1'b1;
            if (!wdata[0]) begin
               nest_mode <= 1'b0;
               auto_eoi  <= 1'b0;
            end
         end else if (kind == K_DATA) begin
            unique case (phase)
               PH_IDLE: ;
               PH_BASE: begin
                  vec_base <= wdata & BASE_MASK;
                  phase    <= PH_CASC;
               end
               PH_CASC: phase <= need4 ? PH_MODE : PH_IDLE;
               PH_MODE: begin
                  nest_mode <= wdata[4];
                  auto_eoi  <= wdata[1];
                  phase     <= PH_IDLE;
               end
            endcase
         end
      end
   end

   p_init_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kind == K_INIT |=> (phase == PH_BASE) && init_stb);
   p_keep_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_INIT) && wdata[0] |=> $stable(nest_mode) && $stable(auto_eoi));
   p_base_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_DATA) && (phase == PH_BASE) |=> phase == PH_CASC);
   p_mode_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_DATA) && (phase == PH_MODE) |=> phase == PH_IDLE);
endmodule

// File: rtl/pic_seq_ctrl.sv
module pic_seq_ctrl
   import pic_seq_pkg::*;
#(
   parameter int LINES = 8,
   localparam int DATA_W = LINES,
   localparam int IRQ_W = $clog2(LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  kind_e             kind,
   input  op_e               op,
   input  phase_e            phase,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              poll_valid,
   input  logic [IRQ_W-1:0]  poll_irq,
   output logic [DATA_W-1:0] imr,
   output logic              smask,
   output logic              rd_isr,
   output logic              poll_armed,
   output logic              rot_aeoi,
   output logic              cmd_stb,
   output op_e               cmd_op,
   output logic [IRQ_W-1:0]  cmd_irq,
   output logic              poll_ack,
   output logic [IRQ_W-1:0]  poll_ack_irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr          <= '0;
         smask        <= 1'b0;
         rd_isr       <= 1'b0;
         poll_armed   <= 1'b0;
         rot_aeoi     <= 1'b0;
         cmd_stb      <= 1'b0;
         cmd_op       <= OP_NOP;
         cmd_irq      <= '0;
         poll_ack     <= 1'b0;
         poll_ack_irq <= '0;
      end else begin
         cmd_stb  <= 1'b0;
         poll_ack <= 1'b0;
         // a read consumes an armed poll; a same-cycle re-arm below wins
         if (rd_en && poll_armed) begin
            poll_armed   <= 1'b0;
            poll_ack     <= poll_valid;
            poll_ack_irq <= poll_irq;
         end
         unique case (kind)
            K_INIT: begin
               imr    <= '0;
               smask  <= 1'b0;
               rd_isr <= 1'b0;
            end
            K_DATA: if (phase == PH_IDLE) imr <= wdata;
            K_SEL: begin
               if (wdata[2]) poll_armed <= 1'b1;
               if (wdata[1]) rd_isr     <= wdata[0];
               if (wdata[6]) smask      <= wdata[5];
            end
            K_OPR: begin
               unique case (op)
                  OP_ROT_OFF: rot_aeoi <= 1'b0;
                  OP_ROT_ON:  rot_aeoi <= 1'b1;
                  OP_NOP:     ;
                  default: begin
                     cmd_stb <= 1'b1;
                     cmd_op  <= op;
                     cmd_irq <= wdata[IRQ_W-1:0];
                  end
               endcase
            end
            default: ;
         endcase
      end
   end

   p_imr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_DATA) && (phase != PH_IDLE) |=> $stable(imr));
   p_poll_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && poll_armed && (kind != K_SEL) |=> !poll_armed);
   p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_OPR) && (op == OP_NOP) |=> !cmd_stb);
   p_rot_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_OPR) && ((op == OP_ROT_ON) || (op == OP_ROT_OFF)) |=> !cmd_stb);
endmodule

// File: rtl/pic_seq_rdmux.sv
module pic_seq_rdmux #(
   parameter int LINES = 8,
   localparam int DATA_W = LINES,
   localparam int IRQ_W = $clog2(LINES)
)(
   input  logic              addr,
   input  logic              rd_isr,
   input  logic              poll_armed,
   input  logic              poll_valid,
   input  logic [IRQ_W-1:0]  poll_irq,
   input  logic [DATA_W-1:0] irr,
   input  logic [DATA_W-1:0] isr,
   input  logic [DATA_W-1:0] imr,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [IRQ_W-1:0] SPUR = IRQ_W'(LINES - 1);

   logic [DATA_W-1:0] poll_word;
   assign poll_word = poll_valid ? {1'b1, {(DATA_W-1-IRQ_W){1'b0}}, poll_irq}
                                 : {{(DATA_W-IRQ_W){1'b0}}, SPUR};

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic reg_bit;
      assign reg_bit  = addr ? imr[b] : (rd_isr ? isr[b] : irr[b]);
      assign rdata[b] = poll_armed ? poll_word[b] : reg_bit;
   end
endmodule

// File: rtl/pic_prog_seq.sv
module pic_prog_seq
   import pic_seq_pkg::*;
#(
   parameter int LINES = 8,
   localparam int DATA_W = LINES,
   localparam int IRQ_W = $clog2(LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] irr_i,
   input  logic [DATA_W-1:0] isr_i,
   input  logic              poll_valid_i,
   input  logic [IRQ_W-1:0]  poll_irq_i,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] vec_base_o,
   output logic [1:0]        init_phase_o,
   output logic              fourth_word_o,
   output logic              nest_mode_o,
   output logic              auto_eoi_o,
   output logic              rot_aeoi_o,
   output logic              spec_mask_o,
   output logic              read_isr_o,
   output logic              poll_armed_o,
   output logic              init_stb_o,
   output logic              cmd_stb_o,
   output logic [2:0]        cmd_op_o,
   output logic [IRQ_W-1:0]  cmd_irq_o,
   output logic              poll_ack_o,
   output logic [IRQ_W-1:0]  poll_irq_ack_o
);
   // command bit positions are fixed to an eight-line byte port
   initial begin
      assert (LINES == 8) else $fatal(1, "pic_prog_seq: LINES must be 8");
   end

   kind_e  kind;
   op_e    op;
   phase_e phase;
   op_e    cmd_op;

   pic_seq_decode u_dec (
      .wr_en  (wr_en),
      .addr   (addr),
      .cmd_hi (wdata[7:3]),
      .kind   (kind),
      .op     (op)
   );

   pic_seq_init #(.LINES(LINES)) u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .wdata     (wdata),
      .phase     (phase),
      .need4     (fourth_word_o),
      .vec_base  (vec_base_o),
      .nest_mode (nest_mode_o),
      .auto_eoi  (auto_eoi_o),
      .init_stb  (init_stb_o)
   );

   pic_seq_ctrl #(.LINES(LINES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .kind         (kind),
      .op           (op),
      .phase        (phase),
      .wdata        (wdata),
      .rd_en        (rd_en),
      .poll_valid   (poll_valid_i),
      .poll_irq     (poll_irq_i),
      .imr          (mask_o),
      .smask        (spec_mask_o),
      .rd_isr       (read_isr_o),
      .poll_armed   (poll_armed_o),
      .rot_aeoi     (rot_aeoi_o),
      .cmd_stb      (cmd_stb_o),
      .cmd_op       (cmd_op),
      .cmd_irq      (cmd_irq_o),
      .poll_ack     (poll_ack_o),
      .poll_ack_irq (poll_irq_ack_o)
   );

   pic_seq_rdmux #(.LINES(LINES)) u_rd (
      .addr       (addr),
      .rd_isr     (read_isr_o),
      .poll_armed (poll_armed_o),
      .poll_valid (poll_valid_i),
      .poll_irq   (poll_irq_i),
      .irr        (irr_i),
      .isr        (isr_i),
      .imr        (mask_o),
      .rdata      (rd_data)
   );

   assign init_phase_o = phase;
   assign cmd_op_o     = cmd_op;

   p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_stb_o, cmd_stb_o}));
endmodule

// File: tb/sim_pic_prog_seq.sv
module sim_pic_prog_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] irr_i = 8'hC3;
   logic [7:0] isr_i = 8'h3C;
   logic       poll_valid_i = 1'b0;
   logic [2:0] poll_irq_i = 3'd0;
   logic [7:0] rd_data, mask_o, vec_base_o;
   logic [1:0] init_phase_o;
   logic       fourth_word_o, nest_mode_o, auto_eoi_o, rot_aeoi_o, spec_mask_o;
   logic       read_isr_o, poll_armed_o, init_stb_o, cmd_stb_o, poll_ack_o;
   logic [2:0] cmd_op_o, cmd_irq_o, poll_irq_ack_o;

   always #10 clk = ~clk;   // 50 MHz

   pic_prog_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .irr_i(irr_i), .isr_i(isr_i), .poll_valid_i(poll_valid_i),
      .poll_irq_i(poll_irq_i), .rd_data(rd_data), .mask_o(mask_o),
      .vec_base_o(vec_base_o), .init_phase_o(init_phase_o),
      .fourth_word_o(fourth_word_o), .nest_mode_o(nest_mode_o),
      .auto_eoi_o(auto_eoi_o), .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o),
      .read_isr_o(read_isr_o), .poll_armed_o(poll_armed_o), .init_stb_o(init_stb_o),
      .cmd_stb_o(cmd_stb_o), .cmd_op_o(cmd_op_o), .cmd_irq_o(cmd_irq_o),
      .poll_ack_o(poll_ack_o), .poll_irq_ack_o(poll_irq_ack_o)
   );

   typedef enum int {
      O_RD, O_MASK, O_BASE, O_PHASE, O_NEST, O_AEOI, O_ROT, O_SMASK, O_RSEL,
      O_POLL, O_ISTB, O_CSTB, O_COP, O_CIRQ, O_PACK, O_PIRQ, O_NEED4
   } obs_e;

   typedef struct {
      obs_e       id;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t exp_q[$];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   function automatic logic [7:0] observe(obs_e id);
      case (id)
         O_RD:    return rd_data;
         O_MASK:  return mask_o;
         O_BASE:  return vec_base_o;
         O_PHASE: return {6'd0, init_phase_o};
         O_NEST:  return {7'd0, nest_mode_o};
         O_AEOI:  return {7'd0, auto_eoi_o};
         O_ROT:   return {7'd0, rot_aeoi_o};
         O_SMASK: return {7'd0, spec_mask_o};
         O_RSEL:  return {7'd0, read_isr_o};
         O_POLL:  return {7'd0, poll_armed_o};
         O_ISTB:  return {7'd0, init_stb_o};
         O_CSTB:  return {7'd0, cmd_stb_o};
         O_COP:   return {5'd0, cmd_op_o};
         O_CIRQ:  return {5'd0, cmd_irq_o};
         O_PACK:  return {7'd0, poll_ack_o};
         O_PIRQ:  return {5'd0, poll_irq_ack_o};
         default: return {7'd0, fourth_word_o};
      endcase
   endfunction

   task automatic expect_v(obs_e id, logic [7:0] v, string tag);
      item_t it;
      it.id = id; it.exp = v; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: compares queued expectations 5 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = exp_q.pop_front();
            got = observe(it.id);
            checks++;
            if (got !== it.exp) begin
               failures++;
               $display("FAIL %s obs=%s actual=%02h expected=%02h", it.tag, it.id.name(), got, it.exp);
            end
         end
      end
   end

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wdata = 8'h00;
   endtask

   task automatic rd_chk(logic a, logic [7:0] v, string tag);
      @(negedge clk); #1;
      rd_en = 1'b1; addr = a;
      expect_v(O_RD, v, tag);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      expect_v(O_MASK, 8'h00, "R1");
      expect_v(O_PHASE, 8'h00, "R1");
      expect_v(O_NEST, 8'h00, "R1");
      expect_v(O_AEOI, 8'h00, "R1");
      expect_v(O_POLL, 8'h00, "R1");
      expect_v(O_ISTB, 8'h00, "R1");
      expect_v(O_CSTB, 8'h00, "R1");
      rd_chk(1'b1, 8'h00, "R1 mask read");

      // full four-word init
      wr(1'b0, 8'h11);
      expect_v(O_ISTB, 8'h01, "R2");
      expect_v(O_PHASE, 8'h01, "R2");
      expect_v(O_NEED4, 8'h01, "R2");
      wr(1'b1, 8'h47);
      expect_v(O_BASE, 8'h40, "R4 base masked");
      expect_v(O_PHASE, 8'h02, "R4");
      expect_v(O_ISTB, 8'h00, "R2 single pulse");
      wr(1'b1, 8'h00);
      expect_v(O_PHASE, 8'h03, "R4 to mode word");
      wr(1'b1, 8'h12);
      expect_v(O_NEST, 8'h01, "R5");
      expect_v(O_AEOI, 8'h01, "R5");
      expect_v(O_PHASE, 8'h00, "R5");

      // mask load and readback
      wr(1'b1, 8'hA5);
      expect_v(O_MASK, 8'hA5, "R6");
      rd_chk(1'b1, 8'hA5, "R9 mask read");
      rd_chk(1'b0, 8'hC3, "R9 irr read");

      // select command
      wr(1'b0, 8'h6B);
      expect_v(O_SMASK, 8'h01, "R7");
      expect_v(O_RSEL, 8'h01, "R7");
      rd_chk(1'b0, 8'h3C, "R9 isr read");
      wr(1'b0, 8'h28);   // enables clear: fields hold
      expect_v(O_SMASK, 8'h01, "R7 gated");
      expect_v(O_RSEL, 8'h01, "R7 gated");

      // init with level/single bits and fourth word: mode flags kept
      wr(1'b0, 8'h1B);
      expect_v(O_ISTB, 8'h01, "R12");
      expect_v(O_PHASE, 8'h01, "R12");
      expect_v(O_MASK, 8'h00, "R2 mask cleared");
      expect_v(O_SMASK, 8'h00, "R2");
      expect_v(O_RSEL, 8'h00, "R2");
      expect_v(O_NEST, 8'h01, "R3 kept");
      expect_v(O_AEOI, 8'h01, "R3 kept");
      rd_chk(1'b0, 8'hC3, "R2 read select back to irr");
      wr(1'b1, 8'h3F);
      expect_v(O_BASE, 8'h38, "R4");
      expect_v(O_MASK, 8'h00, "R6 base word not mask");
      wr(1'b1, 8'hFF);
      expect_v(O_PHASE, 8'h03, "R4");
      expect_v(O_MASK, 8'h00, "R6 cascade word not mask");
      wr(1'b1, 8'h00);
      expect_v(O_NEST, 8'h00, "R5");
      expect_v(O_AEOI, 8'h00, "R5");
      expect_v(O_MASK, 8'h00, "R6 mode word not mask");

      // set nested mode, then init without fourth word clears it
      wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h10);
      expect_v(O_NEST, 8'h01, "R5");
      wr(1'b0, 8'h10);
      expect_v(O_NEST, 8'h00, "R3 cleared");
      expect_v(O_NEED4, 8'h00, "R2");
      wr(1'b1, 8'h27);
      expect_v(O_BASE, 8'h20, "R4");
      wr(1'b1, 8'h00);
      expect_v(O_PHASE, 8'h00, "R4 skip mode word");
      wr(1'b1, 8'h0F);
      expect_v(O_MASK, 8'h0F, "R6");

      // operation commands
      wr(1'b0, 8'h80);
      expect_v(O_ROT, 8'h01, "R10");
      expect_v(O_CSTB, 8'h00, "R10");
      wr(1'b0, 8'h00);
      expect_v(O_ROT, 8'h00, "R10");
      expect_v(O_CSTB, 8'h00, "R10");
      wr(1'b0, 8'h20);
      expect_v(O_CSTB, 8'h01, "R11"); expect_v(O_COP, 8'h01, "R11");
      idle();
      expect_v(O_CSTB, 8'h00, "R11 single pulse");
      wr(1'b0, 8'h63);
      expect_v(O_CSTB, 8'h01, "R11"); expect_v(O_COP, 8'h03, "R11"); expect_v(O_CIRQ, 8'h03, "R11");
      wr(1'b0, 8'hA6);
      expect_v(O_COP, 8'h05, "R11"); expect_v(O_CIRQ, 8'h06, "R11");
      wr(1'b0, 8'hC5);
      expect_v(O_COP, 8'h06, "R11"); expect_v(O_CIRQ, 8'h05, "R11");
      wr(1'b0, 8'hE2);
      expect_v(O_CSTB, 8'h01, "R11"); expect_v(O_COP, 8'h07, "R11"); expect_v(O_CIRQ, 8'h02, "R11");
      wr(1'b0, 8'h47);
      expect_v(O_CSTB, 8'h00, "R11 no-op code");

      // poll with a pending request
      poll_valid_i = 1'b1; poll_irq_i = 3'd5;
      wr(1'b0, 8'h0C);
      expect_v(O_POLL, 8'h01, "R8");
      rd_chk(1'b1, 8'h85, "R8 poll result");
      expect_v(O_POLL, 8'h00, "R8 disarm");
      expect_v(O_PACK, 8'h01, "R8");
      expect_v(O_PIRQ, 8'h05, "R8");
      rd_chk(1'b1, 8'h0F, "R8 one-shot");
      expect_v(O_PACK, 8'h00, "R8");
      // poll with nothing pending
      poll_valid_i = 1'b0;
      wr(1'b0, 8'h0C);
      rd_chk(1'b0, 8'h07, "R8 spurious");
      expect_v(O_PACK, 8'h00, "R8");
      expect_v(O_POLL, 8'h00, "R8");

      idle(); idle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule